// File: doc/BRIEF.md
# Channel-Associated Signalling Receive Unit

This unit sits after the receive framer of a 2.048 Mbit/s trunk. It takes in the time-slot-16 byte of each frame, together with that frame's position inside the 16-frame signalling multiframe. From these bytes it recovers the four-bit ABCD signalling state of each of the 30 voice channels. In frames 1 to 15, the upper nibble belongs to channel f and the lower nibble to channel f+15. Frame 0 carries the multiframe alignment word, which the unit keeps as well.

The recovered states live in a 30-entry register array that a host reads one channel at a time. While the multiframe-sync flag is low, the stored states and the alignment word hold their values, and updating resumes once sync returns. Debounce can be enabled for all channels at once. With debounce on, a new state must arrive unchanged on seven consecutive multiframes, which is 14 ms, before it replaces the stored one. Every change to a stored state can raise a single interrupt, and that interrupt carries a fixed vector.

Top module: `cas_sig_rx`

## Requirements
- R1: When `slot_valid` is high with `frame_num`=f (1..15), bits 7:4 of `slot_byte` belong to read index f-1 and bits 3:0 belong to read index f+14. `rd_data` shows the stored nibble at index `rd_addr` one clock after the address is presented.
- R2: With `deb_en`=0 and `mf_sync`=1, a sampled nibble that differs from the stored one replaces it on the sampling clock.
- R3: While `mf_sync`=0, slot bytes are ignored: stored nibbles and `mfa_word` keep their values. Updating resumes with the first byte sampled after `mf_sync` returns to 1.
- R4: A byte sampled with `frame_num`=0 and `mf_sync`=1 is copied into `mfa_word` and changes no channel nibble.
- R5: With `deb_en`=1, a differing value replaces the stored nibble only on its 7th consecutive identical sample for that channel. After 6 such samples the old value is still stored.
- R6: With `deb_en`=1, a sample that differs from the pending candidate restarts the count, so the candidate then needs 7 fresh identical samples.
- R7: With `irq_mask`=0, a change of any stored nibble sets `irq` one clock after the change. `irq` then stays high until a clock with `irq_ack`=1.
- R8: A stored-nibble change that occurs while `irq_mask`=1 does not raise `irq`.
- R9: `irq_vec` reads 8'h01 whenever `irq` is high and 8'h00 otherwise.
- R10: After reset, all nibbles, `rd_data`, `mfa_word`, `irq` and `irq_vec` are zero.
- R11: A `rd_addr` of 30 or above reads 0.
- R12: A sample equal to the stored nibble causes no change and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | Slot-16 byte strobe |
| slot_byte | input | 8 | Received slot-16 byte |
| frame_num | input | 4 | Frame position within the multiframe |
| mf_sync | input | 1 | High while multiframe alignment is held |
| deb_en | input | 1 | Enables the 7-multiframe debounce |
| irq_mask | input | 1 | 1 blocks new change interrupts |
| irq_ack | input | 1 | Clears the pending interrupt |
| rd_addr | input | 5 | Channel index to read (0..29) |
| rd_data | output | 4 | Registered nibble read data |
| mfa_word | output | 8 | Last frame-0 byte received in sync |
| irq | output | 1 | Change interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
A byte that is presented before a clock edge updates the stored nibbles and `mfa_word` at that edge. `irq` and `irq_vec` follow at the next edge, and `rd_data` shows the new value at the edge after the address is applied. The bench drives its inputs on falling edges. It deasserts the strobe one falling edge after presenting the byte, then sets the read address and samples `rd_data`, `irq` and `irq_vec` one falling edge later, which is after both of those registers have loaded. The debounce cases read the channel between samples, so the 6th and 7th samples are seen as separate events.

// File: rtl/cas_rx_pkg.sv
package cas_rx_pkg;
  parameter int unsigned CAS_CH      = 30;
  parameter int unsigned CAS_NIB_W   = 4;
  parameter int unsigned CAS_FRM_W   = 4;
  parameter int unsigned CAS_DEB_MF  = 7;
  parameter logic [7:0]  CAS_VEC     = 8'h01;
endpackage

// File: rtl/cas_slot_demux.sv
module cas_slot_demux #(
  parameter int unsigned NUM_CH = 30,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned FRM_W  = 4,
  localparam int unsigned HALF  = NUM_CH / 2,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic                          slot_valid,
  input  logic [BYTE_W-1:0]             slot_byte,
  input  logic [FRM_W-1:0]              frame_num,
  input  logic                          mf_sync,
  output logic [NUM_CH-1:0]             ch_en,
  output logic [NUM_CH-1:0][NIB_W-1:0]  ch_val,
  output logic                          mfa_en
);
  logic live;
  assign live   = slot_valid && mf_sync;
  assign mfa_en = live && (frame_num == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map
    localparam bit          UPPER = (ch < HALF);
    localparam int unsigned FRM   = UPPER ? ch + 1 : ch - HALF + 1;
    assign ch_en[ch]  = live && (frame_num == FRM_W'(FRM));
    if (UPPER) begin : g_hi
      assign ch_val[ch] = slot_byte[BYTE_W-1:NIB_W];
    end else begin : g_lo
      assign ch_val[ch] = slot_byte[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/cas_chan_cell.sv
module cas_chan_cell #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DEB_MF = 7,
  localparam int unsigned CNT_W = $clog2(DEB_MF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic [NIB_W-1:0] smp_val,
  input  logic             deb_en,
  output logic [NIB_W-1:0] nib_o,
  output logic             chg_o
);
  logic [NIB_W-1:0] nib_q, cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic             chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (smp_en) begin
        if (!deb_en) begin
          cand_q <= smp_val;
          cnt_q  <= '0;
          if (smp_val != nib_q) begin
            nib_q <= smp_val;
            chg_q <= 1'b1;
          end
        end else if (smp_val == nib_q) begin
          cand_q <= smp_val;
          cnt_q  <= '0;
        end else if (smp_val != cand_q) begin
          cand_q <= smp_val;
          cnt_q  <= CNT_W'(1);
        end else if (cnt_q >= CNT_W'(DEB_MF - 1)) begin
          nib_q <= smp_val;
          chg_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign nib_o = nib_q;
  assign chg_o = chg_q;

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(nib_q));
  // R12
  same_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && smp_val == nib_q) |=> (!chg_q && $stable(nib_q)));
endmodule

// File: rtl/cas_irq_ctrl.sv
module cas_irq_ctrl #(
  parameter logic [7:0] VEC = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       any_chg,
  input  logic       irq_mask,
  input  logic       irq_ack,
  output logic       irq,
  output logic [7:0] irq_vec
);
  logic       irq_q, irq_d;
  logic [7:0] vec_q;

  always_comb begin
    irq_d = irq_q;
    if (irq_ack)               irq_d = 1'b0;
    if (any_chg && !irq_mask)  irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= irq_d ? VEC : 8'h00;
    end
  end

  assign irq     = irq_q;
  assign irq_vec = vec_q;

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_ack) |=> irq_q);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_mask && !irq_q) |=> !irq_q);
  // R9
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    vec_q == (irq_q ? VEC : 8'h00));
endmodule

// File: rtl/cas_sig_rx.sv
module cas_sig_rx
  import cas_rx_pkg::*;
#(
  parameter int unsigned NUM_CH = CAS_CH,
  parameter int unsigned NIB_W  = CAS_NIB_W,
  parameter int unsigned FRM_W  = CAS_FRM_W,
  parameter int unsigned DEB_MF = CAS_DEB_MF,
  parameter logic [7:0]  VEC    = CAS_VEC,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_valid,
  input  logic [BYTE_W-1:0] slot_byte,
  input  logic [FRM_W-1:0]  frame_num,
  input  logic              mf_sync,
  input  logic              deb_en,
  input  logic              irq_mask,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NIB_W-1:0]  rd_data,
  output logic [BYTE_W-1:0] mfa_word,
  output logic              irq,
  output logic [7:0]        irq_vec
);
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0][NIB_W-1:0] ch_val;
  logic [NUM_CH-1:0][NIB_W-1:0] nib_all;
  logic [NUM_CH-1:0]            chg_all;
  logic                         mfa_en;
  logic [BYTE_W-1:0]            mfa_q;
  logic [NIB_W-1:0]             rd_q;

  cas_slot_demux #(.NUM_CH(NUM_CH), .NIB_W(NIB_W), .FRM_W(FRM_W)) u_demux (
    .slot_valid(slot_valid), .slot_byte(slot_byte), .frame_num(frame_num),
    .mf_sync(mf_sync), .ch_en(ch_en), .ch_val(ch_val), .mfa_en(mfa_en));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
    cas_chan_cell #(.NIB_W(NIB_W), .DEB_MF(DEB_MF)) u_cell (
      .clk(clk), .rst(rst), .smp_en(ch_en[ch]), .smp_val(ch_val[ch]),
      .deb_en(deb_en), .nib_o(nib_all[ch]), .chg_o(chg_all[ch]));
  end

  cas_irq_ctrl #(.VEC(VEC)) u_irq (
    .clk(clk), .rst(rst), .any_chg(|chg_all), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .irq(irq), .irq_vec(irq_vec));

  always_ff @(posedge clk) begin
    if (rst) begin
      mfa_q <= '0;
      rd_q  <= '0;
    end else begin
      if (mfa_en) mfa_q <= slot_byte;
      rd_q <= (32'(rd_addr) < NUM_CH) ? nib_all[rd_addr] : '0;
    end
  end

  assign mfa_word = mfa_q;
  assign rd_data  = rd_q;

  // R3
  mfa_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !mf_sync |=> $stable(mfa_q));
  // R11
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr) >= NUM_CH) |=> (rd_q == '0));
endmodule

// File: tb/cas_sig_rx_bench.sv
module cas_sig_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_valid = 1'b0;
  logic [7:0] slot_byte = '0;
  logic [3:0] frame_num = '0;
  logic       mf_sync = 1'b1;
  logic       deb_en = 1'b0;
  logic       irq_mask = 1'b0;
  logic       irq_ack = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic [7:0] mfa_word;
  logic       irq;
  logic [7:0] irq_vec;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cas_sig_rx u_cas_sig_rx (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_byte(slot_byte),
    .frame_num(frame_num), .mf_sync(mf_sync), .deb_en(deb_en),
    .irq_mask(irq_mask), .irq_ack(irq_ack), .rd_addr(rd_addr),
    .rd_data(rd_data), .mfa_word(mfa_word), .irq(irq), .irq_vec(irq_vec));

  // {frame, byte, sync, read addr, expected nibble, expected irq}
  localparam logic [22:0] TBL [8] = '{
    {4'd1,  8'hA5, 1'b1, 5'd0,  4'hA, 1'b1},
    {4'd1,  8'hA5, 1'b1, 5'd15, 4'h5, 1'b0},
    {4'd15, 8'h3C, 1'b1, 5'd14, 4'h3, 1'b1},
    {4'd15, 8'h3C, 1'b1, 5'd29, 4'hC, 1'b0},
    {4'd7,  8'h96, 1'b0, 5'd6,  4'h0, 1'b0},
    {4'd7,  8'h96, 1'b1, 5'd21, 4'h6, 1'b1},
    {4'd0,  8'h0B, 1'b1, 5'd0,  4'hA, 1'b0},
    {4'd3,  8'h00, 1'b1, 5'd2,  4'h0, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] f, input logic [7:0] b, input logic s);
    frame_num = f; slot_byte = b; mf_sync = s; slot_valid = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0; mf_sync = 1'b1;
  endtask

  task automatic read(input logic [4:0] a);
    rd_addr = a;
    @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    read(5'd0);
    // R10 reset state
    check("R10 rd", rd_data, 0);
    check("R10 irq", irq, 0);
    check("R10 vec", irq_vec, 0);
    check("R10 mfa", mfa_word, 0);

    for (int i = 0; i < 8; i++) begin
      send(TBL[i][22:19], TBL[i][18:11], TBL[i][10]);
      read(TBL[i][9:5]);
      // R1 R2 R3 R12 mapping, update, freeze, no-change
      check("R1/R2/R3 rd", rd_data, TBL[i][4:1]);
      check("R7/R12 irq", irq, TBL[i][0]);
      ack();
    end

    // R4 frame 0 word
    check("R4 mfa", mfa_word, 8'h0B);
    // R3 frozen alignment word
    send(4'd0, 8'hFF, 1'b0);
    read(5'd0);
    check("R3 mfa frozen", mfa_word, 8'h0B);

    // R11 out-of-range read
    read(5'd30);
    check("R11 rd", rd_data, 0);

    // R8 masked change
    irq_mask = 1'b1;
    send(4'd4, 8'h10, 1'b1);
    read(5'd3);
    check("R8 rd", rd_data, 1);
    check("R8 irq", irq, 0);
    irq_mask = 1'b0;

    // R7 hold until ack, R9 vector
    send(4'd5, 8'h20, 1'b1);
    read(5'd4);
    repeat (4) @(negedge clk);
    check("R7 irq held", irq, 1);
    check("R9 vec", irq_vec, 8'h01);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R7 irq cleared", irq, 0);
    check("R9 vec cleared", irq_vec, 0);

    // R5 debounce needs 7 samples
    deb_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      send(4'd2, 8'h70, 1'b1);
      read(5'd1);
    end
    check("R5 after 6", rd_data, 0);
    check("R5 no irq", irq, 0);
    send(4'd2, 8'h70, 1'b1);
    read(5'd1);
    check("R5 after 7", rd_data, 7);
    check("R5 irq", irq, 1);
    ack();

    // R6 restart on differing sample
    for (int k = 0; k < 3; k++) begin send(4'd2, 8'h20, 1'b1); read(5'd1); end
    send(4'd2, 8'h30, 1'b1); read(5'd1);
    for (int k = 0; k < 6; k++) begin send(4'd2, 8'h20, 1'b1); read(5'd1); end
    check("R6 restarted", rd_data, 7);
    send(4'd2, 8'h20, 1'b1);
    read(5'd1);
    check("R6 accepted", rd_data, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule